// File: doc/BRIEF.md
# Interrupt Storm Detector with Polling Fallback

This block sits between several sources of threshold interrupts and the interrupt controller. Each channel watches its own stream of event pulses. It counts how many events land inside a fixed window of ticks, where a free-running tick counter marks time. An event that falls outside the current window starts a new window at the present tick value, with a count of one. When a channel sees more events in one window than a configured limit, it masks its interrupt path, raises a storm flag and turns into a periodic poller. In that state it issues one poll request for every window length of ticks, and it absorbs any further events without counting them.

The storm state holds until software pulses the channel's clear input. A clear turns the interrupt path back on and zeroes the event count. All channels share one tally of how many of them are in storm. A one-cycle notice flag goes high only when that tally leaves zero, so only the first channel to trip is announced. Window comparisons use a signed difference of tick values, so they stay correct when the tick counter wraps around.

Top module: `storm_guard_top`

## Requirements
- R1: After reset every `irq_en_o` bit is 1, and `storm_o`, `poll_o`, `swallow_o`, `notice_o` and `active_o` are all 0. The tick counter, every window start and every event count are 0.
- R2: While a channel is in storm, an event on its input produces a `swallow_o` pulse in the next cycle. The event leaves the count, the window and the storm state unchanged.
- R3: The tick value is the number of cycles with `tick_i` high since reset, modulo 2^TW. For a channel not in storm, an event in a cycle where the TW-bit difference (tick − window start), read as two's complement, is at most INTERVAL adds one to the count. Any other event sets the count to 1 and loads the window start with the tick value.
- R4: A channel enters storm at the clock edge that samples the event raising its count above LIMIT (default 15). A count equal to LIMIT leaves the channel in normal operation.
- R5: In the cycle a channel enters storm, its `storm_o` goes to 1 and its `irq_en_o` goes to 0.
- R6: A clear on a channel takes effect at the next edge. It returns the channel to normal operation with `irq_en_o` = 1 and a count of 0. An event on that channel in the same cycle is dropped.
- R7: While in storm, `poll_o` pulses for one cycle after every INTERVAL-th `tick_i`, counting from storm entry. It never pulses outside storm.
- R8: `notice_o` is 1 exactly in the cycles where at least one channel is in storm and none was in the cycle before.
- R9: `active_o` equals the number of channels currently in storm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Advances the free-running tick counter |
| evt_i | input | NCH | Threshold event pulse per channel |
| clr_i | input | NCH | Software storm clear per channel |
| irq_en_o | output | NCH | Interrupt path enabled per channel |
| poll_o | output | NCH | Poll request pulse per channel |
| swallow_o | output | NCH | Event absorbed during storm |
| storm_o | output | NCH | Channel in storm state |
| notice_o | output | 1 | First storm entry among all channels |
| active_o | output | $clog2(NCH+1) | Count of channels in storm |

## Verification
The bench uses a 6-bit tick counter, so the window start and the current tick often sit on opposite sides of a wrap. A design that compared the values unsigned would then restart windows it should extend, and would trip late or never. Directed bursts place exactly LIMIT and LIMIT+1 events in one window to catch an off-by-one in the trip test. Long mixed streams with random clears probe several cases: a clear arriving together with an event, polls that should restart at storm entry, and both channels tripping in the same cycle. In that last case a design that announced each channel would pulse the notice twice.

// File: rtl/stg_pkg.sv
package stg_pkg;
   typedef enum logic {
      MODE_NORMAL = 1'b0,
      MODE_STORM  = 1'b1
   } stg_mode_e;

   function automatic int unsigned stg_cnt_width(input int unsigned limit);
      return $clog2(limit + 2);
   endfunction
endpackage

// File: rtl/stg_ticker.sv
module stg_ticker #(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   output logic [TW-1:0] now_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      now_o <= '0;
      else if (tick_i) now_o <= now_o + 1'b1;
   end
endmodule

// File: rtl/stg_chan.sv
module stg_chan
   import stg_pkg::*;
#(
   parameter int unsigned TW       = 8,
   parameter int unsigned INTERVAL = 16,
   parameter int unsigned LIMIT    = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic [TW-1:0] now_i,
   input  logic          evt_i,
   input  logic          clr_i,
   output logic          irq_en_o,
   output logic          poll_o,
   output logic          swallow_o,
   output logic          storm_o
);
   localparam int unsigned CW = stg_cnt_width(LIMIT);
   localparam int unsigned PW = $clog2(INTERVAL + 1);
   localparam logic signed [TW:0] WIN_S   = (TW+1)'(INTERVAL);
   localparam logic [CW-1:0]      LIM_C   = CW'(LIMIT);
   localparam logic [PW-1:0]      PLAST   = PW'(INTERVAL - 1);

   stg_mode_e        mode_q;
   logic [CW-1:0]    cnt_q;
   logic [TW-1:0]    start_q;
   logic [PW-1:0]    pcnt_q;
   logic             irq_q, poll_q, swl_q;

   logic [TW-1:0]    diff;
   logic signed [TW:0] sdiff;
   logic             in_win;
   logic [CW-1:0]    cnt_nx;
   logic             trip;

   always_comb begin
      diff   = now_i - start_q;
      sdiff  = {diff[TW-1], diff};
      in_win = (sdiff <= WIN_S);
      cnt_nx = in_win ? cnt_q + 1'b1 : CW'(1);
      trip   = (cnt_nx > LIM_C);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MODE_NORMAL;
         cnt_q   <= '0;
         start_q <= '0;
         pcnt_q  <= '0;
         irq_q   <= 1'b1;
         poll_q  <= 1'b0;
         swl_q   <= 1'b0;
      end else begin
         poll_q <= 1'b0;
         swl_q  <= 1'b0;
         if (clr_i) begin
            mode_q <= MODE_NORMAL;
            irq_q  <= 1'b1;
            cnt_q  <= '0;
            pcnt_q <= '0;
         end else if (mode_q == MODE_STORM) begin
            swl_q <= evt_i;
            if (tick_i) begin
               if (pcnt_q == PLAST) begin
                  poll_q <= 1'b1;
                  pcnt_q <= '0;
               end else begin
                  pcnt_q <= pcnt_q + 1'b1;
               end
            end
         end else if (evt_i) begin
            cnt_q <= cnt_nx;
            if (!in_win) start_q <= now_i;
            if (trip) begin
               mode_q <= MODE_STORM;
               irq_q  <= 1'b0;
               pcnt_q <= '0;
            end
         end
      end
   end

   assign irq_en_o  = irq_q;
   assign poll_o    = poll_q;
   assign swallow_o = swl_q;
   assign storm_o   = (mode_q == MODE_STORM);
endmodule

// File: rtl/stg_share.sv
module stg_share #(
   parameter int unsigned NCH = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NCH-1:0]             storm_i,
   output logic [$clog2(NCH+1)-1:0]   active_o,
   output logic                       notice_o
);
   localparam int unsigned AW = $clog2(NCH + 1);

   logic any_q;

   always_comb begin
      active_o = '0;
      for (int i = 0; i < NCH; i++) active_o = active_o + AW'(storm_i[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) any_q <= 1'b0;
      else        any_q <= (active_o != '0);
   end

   assign notice_o = (active_o != '0) && !any_q;
endmodule

// File: rtl/storm_guard_top.sv
module storm_guard_top #(
   parameter int unsigned NCH      = 2,
   parameter int unsigned TW       = 8,
   parameter int unsigned INTERVAL = 16,
   parameter int unsigned LIMIT    = 15
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick_i,
   input  logic [NCH-1:0]             evt_i,
   input  logic [NCH-1:0]             clr_i,
   output logic [NCH-1:0]             irq_en_o,
   output logic [NCH-1:0]             poll_o,
   output logic [NCH-1:0]             swallow_o,
   output logic [NCH-1:0]             storm_o,
   output logic                       notice_o,
   output logic [$clog2(NCH+1)-1:0]   active_o
);
   generate
      if (NCH < 1)                    $error("NCH must be at least 1");
      if (TW < 2)                     $error("TW must be at least 2");
      if (INTERVAL < 1)               $error("INTERVAL must be at least 1");
      if (INTERVAL >= (1 << (TW-1)))  $error("INTERVAL must be below half the tick range");
   endgenerate

   logic [TW-1:0] now;

   stg_ticker #(.TW(TW)) u_ticker (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .now_o  (now)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      stg_chan #(
         .TW       (TW),
         .INTERVAL (INTERVAL),
         .LIMIT    (LIMIT)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_i    (tick_i),
         .now_i     (now),
         .evt_i     (evt_i[g]),
         .clr_i     (clr_i[g]),
         .irq_en_o  (irq_en_o[g]),
         .poll_o    (poll_o[g]),
         .swallow_o (swallow_o[g]),
         .storm_o   (storm_o[g])
      );
   end

   stg_share #(.NCH(NCH)) u_share (
      .clk      (clk),
      .rst_n    (rst_n),
      .storm_i  (storm_o),
      .active_o (active_o),
      .notice_o (notice_o)
   );
endmodule

// File: rtl/stg_check.sv
module stg_check #(
   parameter int unsigned NCH = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NCH-1:0]             evt_i,
   input logic [NCH-1:0]             clr_i,
   input logic [NCH-1:0]             irq_en_o,
   input logic [NCH-1:0]             poll_o,
   input logic [NCH-1:0]             swallow_o,
   input logic [NCH-1:0]             storm_o,
   input logic                       notice_o,
   input logic [$clog2(NCH+1)-1:0]   active_o
);
   localparam int unsigned AW = $clog2(NCH + 1);

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         irq_en_o[g] != storm_o[g]);                                   // R5
      AST_POLL_IN_STORM: assert property (@(posedge clk) disable iff (!rst_n)
         poll_o[g] |-> storm_o[g]);                                    // R7
      AST_SWALLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         swallow_o[g] |-> ($past(storm_o[g]) && $past(evt_i[g])));      // R2
      AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(storm_o[g]) |-> ($past(evt_i[g]) && !$past(clr_i[g])));  // R4
      AST_CLEAR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
         clr_i[g] |=> (!storm_o[g] && irq_en_o[g]));                   // R6
   end

   AST_ACTIVE_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
      active_o == AW'($countones(storm_o)));                          // R9
   AST_NOTICE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      notice_o |-> ((storm_o != '0) && ($past(storm_o) == '0)));        // R8
endmodule

bind storm_guard_top stg_check #(.NCH(NCH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_i     (evt_i),
   .clr_i     (clr_i),
   .irq_en_o  (irq_en_o),
   .poll_o    (poll_o),
   .swallow_o (swallow_o),
   .storm_o   (storm_o),
   .notice_o  (notice_o),
   .active_o  (active_o)
);

// File: tb/storm_guard_top_tb.sv
module storm_guard_top_tb;
   localparam int NCH = 2;
   localparam int TW  = 6;
   localparam int IV  = 8;
   localparam int LIM = 15;
   localparam int AW  = $clog2(NCH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_i = 1'b0;
   logic [NCH-1:0] evt_i = '0, clr_i = '0;
   logic [NCH-1:0] irq_en_o, poll_o, swallow_o, storm_o;
   logic notice_o;
   logic [AW-1:0] active_o;

   always #5 clk = ~clk;

   storm_guard_top #(.NCH(NCH), .TW(TW), .INTERVAL(IV), .LIMIT(LIM)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .evt_i(evt_i), .clr_i(clr_i),
      .irq_en_o(irq_en_o), .poll_o(poll_o), .swallow_o(swallow_o),
      .storm_o(storm_o), .notice_o(notice_o), .active_o(active_o));

   int errors = 0, checks = 0;
   bit done = 0;

   int m_now;
   int m_ts[NCH], m_cnt[NCH], m_pc[NCH];
   bit m_storm[NCH], m_poll[NCH], m_swl[NCH];
   bit m_notice, m_any_prev;
   int m_active;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      for (int i = 0; i < NCH; i++) begin
         chk(storm_o[i] == m_storm[i], "R3 R4 storm_o", storm_o[i], m_storm[i]);
         chk(irq_en_o[i] == !m_storm[i], "R5 R6 irq_en_o", irq_en_o[i], !m_storm[i]);
         chk(poll_o[i] == m_poll[i], "R7 poll_o", poll_o[i], m_poll[i]);
         chk(swallow_o[i] == m_swl[i], "R2 swallow_o", swallow_o[i], m_swl[i]);
      end
      chk(notice_o == m_notice, "R8 notice_o", notice_o, m_notice);
      chk(int'(active_o) == m_active, "R9 active_o", active_o, m_active);
   endtask

   task automatic model(input bit t, input logic [NCH-1:0] e, input logic [NCH-1:0] c);
      bit any_now;
      m_active = 0;
      for (int i = 0; i < NCH; i++) begin
         m_poll[i] = 0;
         m_swl[i]  = 0;
         if (c[i]) begin
            m_storm[i] = 0; m_cnt[i] = 0; m_pc[i] = 0;
         end else if (m_storm[i]) begin
            m_swl[i] = e[i];
            if (t) begin
               if (m_pc[i] == IV - 1) begin m_poll[i] = 1; m_pc[i] = 0; end
               else m_pc[i]++;
            end
         end else if (e[i]) begin
            int d;
            d = (m_now - m_ts[i]) & ((1 << TW) - 1);
            if (d >= (1 << (TW-1))) d -= (1 << TW);
            if (d <= IV) m_cnt[i]++;
            else begin m_cnt[i] = 1; m_ts[i] = m_now; end
            if (m_cnt[i] > LIM) begin m_storm[i] = 1; m_pc[i] = 0; end
         end
         m_active += m_storm[i];
      end
      if (t) m_now = (m_now + 1) & ((1 << TW) - 1);
      any_now = (m_active != 0);
      m_notice = any_now && !m_any_prev;
      m_any_prev = any_now;
   endtask

   task automatic step(input bit t, input logic [NCH-1:0] e, input logic [NCH-1:0] c);
      tick_i = t; evt_i = e; clr_i = c;
      model(t, e, c);
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   initial begin
      m_now = 0; m_notice = 0; m_any_prev = 0; m_active = 0;
      for (int i = 0; i < NCH; i++) begin
         m_ts[i] = 0; m_cnt[i] = 0; m_pc[i] = 0;
         m_storm[i] = 0; m_poll[i] = 0; m_swl[i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(irq_en_o == '1, "R1 irq_en_o", irq_en_o, 3);
      chk(storm_o == '0 && poll_o == '0 && swallow_o == '0, "R1 flags", storm_o, 0);
      chk(notice_o == 0 && active_o == '0, "R1 shared", active_o, 0);

      // R4: exactly LIMIT events in one window stay normal, one more trips
      for (int k = 0; k < LIM; k++) step(0, 2'b01, 2'b00);
      chk(storm_o[0] == 0, "R4 at limit", storm_o[0], 0);
      step(0, 2'b01, 2'b00);
      chk(storm_o[0] == 1 && irq_en_o[0] == 0, "R4 R5 trip", storm_o[0], 1);
      chk(notice_o == 1, "R8 first entry", notice_o, 1);
      // R2: events swallowed; R7: polls every IV ticks
      for (int k = 0; k < 3 * IV; k++) step(1, 2'b01, 2'b00);
      // R6: clear together with an event drops the event
      step(0, 2'b01, 2'b01);
      chk(storm_o[0] == 0 && irq_en_o[0] == 1, "R6 clear", storm_o[0], 0);

      // sweeps across event and tick densities, with random clears
      for (int cyc = 0; cyc < 8000; cyc++) begin
         bit t;
         logic [NCH-1:0] e, c;
         int ph;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         ph = (cyc / 1000) % 4;
         case (ph)
            0: begin t = (lfsr[2:0] == 0);  e[0] = (lfsr[4:3] != 0);  e[1] = lfsr[5]; end
            1: begin t = lfsr[0];           e[0] = (lfsr[4:3] == 0);  e[1] = (lfsr[7:5] != 0); end
            2: begin t = 1'b1;              e[0] = (lfsr[3:0] == 0);  e[1] = lfsr[6]; end
            default: begin t = (lfsr[1:0] == 0); e[0] = lfsr[4]; e[1] = lfsr[9]; end
         endcase
         c[0] = (lfsr[15:10] == 6'd7);
         c[1] = (lfsr[14:9]  == 6'd21);
         step(t, e, c);
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule